// File: doc/BRIEF.md
# Operand Bypass and Load-Use Stall Unit

This block resolves read-after-write hazards for an in-order integer pipeline with five stages: fetch, decode, execute, memory and writeback. It owns the hazard tag register at the front of the execute stage. That register holds the valid, write-enable, load flag, destination and up to three source register numbers of the instruction now executing. For each source, the unit picks the operand from one of three places: the register-file value, the result leaving the execute/memory boundary, or the result leaving the memory/writeback boundary. When both later stages hold a matching result, the younger one wins.

A separate check looks at the instruction waiting in decode. If any register it reads is the destination of a load now in execute, the unit raises `stall`. The surrounding pipeline holds fetch and decode for that cycle. The unit itself loads a bubble into the execute tag register. In the next cycle the load sits in the memory stage, and the waiting instruction then receives the loaded value through the memory/writeback bypass. The register file, ALU and memories lie outside the block. They appear only as register numbers, flags and result buses.

Top module: `fwd_hazard_unit`

## Requirements
- R1: During and right after reset, `ex_valid`, `ex_wr`, `ex_load` and `stall` are 0, and every operand select is register file (code 2'b00).
- R2: If a used execute source equals `mem_dst` while `mem_valid` and `mem_wr` are both 1, that source's select is 2'b01 and its operand equals `mem_result`.
- R3: If a used execute source equals `wb_dst` while `wb_valid` and `wb_wr` are both 1, and R2 does not apply to it, that source's select is 2'b10 and its operand equals `wb_result`.
- R4: If both later stages match the same source, the memory-stage result (2'b01) takes priority.
- R5: A producer is considered only when its valid flag and write flag are both 1. Register number 0 is bypassed like any other register.
- R6: A source with no qualifying match, or whose read-enable was 0 when it was in decode, gets select 2'b00 and its own slice of `rf_data`.
- R7: The three operand slots decide independently. Slot i uses bits [5i+4:5i] of `dec_src`, bit i of `dec_rd_en`, bits [2i+1:2i] of `fwd_sel` and bits [32i+31:32i] of `rf_data`/`ex_opnd`.
- R8: `stall` is 1 in the same cycle when a valid, writing load is in execute and a valid decode instruction reads its destination on an enabled source. In the following cycle, execute holds a bubble: `ex_valid`, `ex_wr` and `ex_load` are all 0.
- R9: A load-use stall lasts exactly one cycle. `stall` is never 1 in two consecutive cycles.
- R10: No stall occurs when execute holds a non-load producer of a register that decode reads, or when the reader comes two or more slots after a load.
- R11: In a cycle without stall, the decode fields are captured into execute at the next edge. `ex_dst` and `ex_load` then reflect the values decode presented, with `ex_valid`, `ex_wr` and `ex_load` qualified by `dec_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_src | input | 15 | Three source register numbers of the decode instruction |
| dec_rd_en | input | 3 | Per-source read enable |
| dec_dst | input | 5 | Destination register of the decode instruction |
| dec_wr | input | 1 | Decode instruction writes a register |
| dec_load | input | 1 | Decode instruction is a load |
| mem_valid | input | 1 | Memory stage holds an instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | 5 | Memory-stage destination register |
| mem_result | input | 32 | Result at the execute/memory boundary |
| wb_valid | input | 1 | Writeback stage holds an instruction |
| wb_wr | input | 1 | Writeback-stage instruction writes a register |
| wb_dst | input | 5 | Writeback-stage destination register |
| wb_result | input | 32 | Result at the memory/writeback boundary |
| rf_data | input | 96 | Register-file values for the three execute sources |
| stall | output | 1 | Hold fetch and decode this cycle |
| ex_valid | output | 1 | Execute holds a real instruction |
| ex_wr | output | 1 | Execute instruction writes a register |
| ex_load | output | 1 | Execute instruction is a load |
| ex_dst | output | 5 | Execute destination register |
| fwd_sel | output | 6 | Per-source select: 00 register file, 01 memory stage, 10 writeback stage |
| ex_opnd | output | 96 | Selected operand values for the three sources |

## Verification
The hardest case to reach is the full load-use sequence. It needs a load in execute, a reader held in decode across the stall, a bubble in execute, and then the same reader entering execute while the load's data sits at the writeback boundary. The stimulus keeps the reader's decode fields steady through the stall cycle. It then advances the load's destination and data down the memory and writeback inputs one cycle apart. A reference model of the execute tag register checks the bubble, the single stall and the later bypass select.

// File: rtl/fwd_hazard_pkg.sv
package fwd_hazard_pkg;
    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_MEM = 2'b01,
        SEL_WB  = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
    import fwd_hazard_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int RAW  = 5
) (
    input  logic [RAW-1:0]  src,
    input  logic            rd_en,
    input  logic            mem_en,
    input  logic [RAW-1:0]  mem_dst,
    input  logic [XLEN-1:0] mem_result,
    input  logic            wb_en,
    input  logic [RAW-1:0]  wb_dst,
    input  logic [XLEN-1:0] wb_result,
    input  logic [XLEN-1:0] rf_val,
    output fwd_sel_e        sel,
    output logic [XLEN-1:0] opnd
);
    logic hit_mem;
    logic hit_wb;

    assign hit_mem = rd_en && mem_en && (mem_dst == src);
    assign hit_wb  = rd_en && wb_en  && (wb_dst  == src);

    always_comb begin
        sel  = SEL_RF;
        opnd = rf_val;
        if (hit_mem) begin
            sel  = SEL_MEM;
            opnd = mem_result;
        end else if (hit_wb) begin
            sel  = SEL_WB;
            opnd = wb_result;
        end
    end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
    parameter int NSRC = 3,
    parameter int RAW  = 5
) (
    input  logic                dec_valid,
    input  logic [NSRC*RAW-1:0] dec_src,
    input  logic [NSRC-1:0]     dec_rd_en,
    input  logic                ex_valid,
    input  logic                ex_wr,
    input  logic                ex_load,
    input  logic [RAW-1:0]      ex_dst,
    output logic                hazard
);
    logic [NSRC-1:0] hit;
    logic            ld_live;

    assign ld_live = ex_valid && ex_wr && ex_load && dec_valid;

    for (genvar i = 0; i < NSRC; i++) begin : g_cmp
        assign hit[i] = dec_rd_en[i] && (dec_src[i*RAW +: RAW] == ex_dst);
    end

    assign hazard = ld_live && (|hit);
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
    import fwd_hazard_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int RAW  = 5,
    parameter int NSRC = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dec_valid,
    input  logic [NSRC*RAW-1:0]  dec_src,
    input  logic [NSRC-1:0]      dec_rd_en,
    input  logic [RAW-1:0]       dec_dst,
    input  logic                 dec_wr,
    input  logic                 dec_load,
    input  logic                 mem_valid,
    input  logic                 mem_wr,
    input  logic [RAW-1:0]       mem_dst,
    input  logic [XLEN-1:0]      mem_result,
    input  logic                 wb_valid,
    input  logic                 wb_wr,
    input  logic [RAW-1:0]       wb_dst,
    input  logic [XLEN-1:0]      wb_result,
    input  logic [NSRC*XLEN-1:0] rf_data,
    output logic                 stall,
    output logic                 ex_valid,
    output logic                 ex_wr,
    output logic                 ex_load,
    output logic [RAW-1:0]       ex_dst,
    output logic [NSRC*2-1:0]    fwd_sel,
    output logic [NSRC*XLEN-1:0] ex_opnd
);
    localparam int SRCW = NSRC * RAW;

    typedef struct packed {
        logic            valid;
        logic            wr;
        logic            load;
        logic [RAW-1:0]  dst;
        logic [SRCW-1:0] src;
        logic [NSRC-1:0] rd_en;
    } ex_tag_t;

    ex_tag_t tag_d, tag_q;
    logic    hazard;
    logic    mem_en;
    logic    wb_en;

    assign mem_en = mem_valid && mem_wr;
    assign wb_en  = wb_valid && wb_wr;

    load_use_detect #(.NSRC(NSRC), .RAW(RAW)) u_ldu (
        .dec_valid (dec_valid),
        .dec_src   (dec_src),
        .dec_rd_en (dec_rd_en),
        .ex_valid  (tag_q.valid),
        .ex_wr     (tag_q.wr),
        .ex_load   (tag_q.load),
        .ex_dst    (tag_q.dst),
        .hazard    (hazard)
    );

    always_comb begin
        tag_d = tag_q;
        if (hazard) begin
            tag_d.valid = 1'b0;
            tag_d.wr    = 1'b0;
            tag_d.load  = 1'b0;
            tag_d.rd_en = '0;
        end else begin
            tag_d.valid = dec_valid;
            tag_d.wr    = dec_valid && dec_wr;
            tag_d.load  = dec_valid && dec_load;
            tag_d.dst   = dec_dst;
            tag_d.src   = dec_src;
            tag_d.rd_en = dec_valid ? dec_rd_en : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tag_q <= '0;
        else        tag_q <= tag_d;
    end

    assign stall    = hazard;
    assign ex_valid = tag_q.valid;
    assign ex_wr    = tag_q.wr;
    assign ex_load  = tag_q.load;
    assign ex_dst   = tag_q.dst;

    for (genvar i = 0; i < NSRC; i++) begin : g_opnd
        fwd_sel_e sel_i;

        fwd_operand_mux #(.XLEN(XLEN), .RAW(RAW)) u_mux (
            .src        (tag_q.src[i*RAW +: RAW]),
            .rd_en      (tag_q.rd_en[i]),
            .mem_en     (mem_en),
            .mem_dst    (mem_dst),
            .mem_result (mem_result),
            .wb_en      (wb_en),
            .wb_dst     (wb_dst),
            .wb_result  (wb_result),
            .rf_val     (rf_data[i*XLEN +: XLEN]),
            .sel        (sel_i),
            .opnd       (ex_opnd[i*XLEN +: XLEN])
        );

        assign fwd_sel[i*2 +: 2] = sel_i;

        // R2: a memory-stage select needs a live memory-stage producer of this source
        p_mem_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (fwd_sel[i*2 +: 2] == 2'b01) |->
                (mem_valid && mem_wr && mem_dst == tag_q.src[i*RAW +: RAW]));

        // R3/R4: a writeback select only when the memory stage does not also match
        p_wb_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (fwd_sel[i*2 +: 2] == 2'b10) |->
                (wb_valid && wb_wr && wb_dst == tag_q.src[i*RAW +: RAW] &&
                 !(mem_valid && mem_wr && mem_dst == tag_q.src[i*RAW +: RAW])));

        p_sel_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
            fwd_sel[i*2 +: 2] != 2'b11);
    end

    // R8: the cycle after a stall carries a bubble in execute
    p_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (!ex_valid && !ex_wr && !ex_load));

    // R9: never two stall cycles in a row
    p_one_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // R10: only a load in execute can cause a stall
    p_load_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (ex_valid && ex_load && ex_wr));

    // R11: decode destination is captured when not stalled
    p_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> (ex_dst == $past(dec_dst)));
endmodule

// File: tb/fwd_hazard_unit_tb.sv
module fwd_hazard_unit_tb;
    localparam int XLEN = 32;
    localparam int RAW  = 5;
    localparam int NSRC = 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 dec_valid = 1'b0;
    logic [NSRC*RAW-1:0]  dec_src = '0;
    logic [NSRC-1:0]      dec_rd_en = '0;
    logic [RAW-1:0]       dec_dst = '0;
    logic                 dec_wr = 1'b0;
    logic                 dec_load = 1'b0;
    logic                 mem_valid = 1'b0;
    logic                 mem_wr = 1'b0;
    logic [RAW-1:0]       mem_dst = '0;
    logic [XLEN-1:0]      mem_result = '0;
    logic                 wb_valid = 1'b0;
    logic                 wb_wr = 1'b0;
    logic [RAW-1:0]       wb_dst = '0;
    logic [XLEN-1:0]      wb_result = '0;
    logic [NSRC*XLEN-1:0] rf_data = '0;
    logic                 stall;
    logic                 ex_valid, ex_wr, ex_load;
    logic [RAW-1:0]       ex_dst;
    logic [NSRC*2-1:0]    fwd_sel;
    logic [NSRC*XLEN-1:0] ex_opnd;

    fwd_hazard_unit #(.XLEN(XLEN), .RAW(RAW), .NSRC(NSRC)) u_dut (.*);

    always #5 clk = ~clk;

    typedef struct {
        string           tag;
        logic            stall;
        logic            exv;
        logic            exw;
        logic            exl;
        logic [RAW-1:0]  exd;
        logic [1:0]      sel [NSRC];
        logic [XLEN-1:0] op  [NSRC];
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    // bench-side model of the execute tag register
    logic           m_v, m_w, m_l;
    logic [RAW-1:0] m_d;
    logic [RAW-1:0] m_src [NSRC];
    logic           m_en  [NSRC];

    // stimulus variables
    logic           s_dv, s_dw, s_dl, s_rst;
    logic [RAW-1:0] s_dd;
    logic [RAW-1:0] s_src [NSRC];
    logic           s_en  [NSRC];
    logic           s_mv, s_mw, s_wv, s_ww;
    logic [RAW-1:0] s_md, s_wd;

    task automatic chk(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic clr();
        s_dv = 0; s_dw = 0; s_dl = 0; s_dd = 0;
        for (int i = 0; i < NSRC; i++) begin s_src[i] = 0; s_en[i] = 0; end
        s_mv = 0; s_mw = 0; s_md = 0; s_wv = 0; s_ww = 0; s_wd = 0;
    endtask

    task automatic model_reset();
        m_v = 0; m_w = 0; m_l = 0; m_d = 0;
        for (int i = 0; i < NSRC; i++) begin m_src[i] = 0; m_en[i] = 0; end
    endtask

    task automatic step(string tag);
        exp_t e;
        logic hit;
        @(negedge clk);
        rst_n     = s_rst;
        dec_valid = s_dv; dec_wr = s_dw; dec_load = s_dl; dec_dst = s_dd;
        for (int i = 0; i < NSRC; i++) begin
            dec_src[i*RAW +: RAW] = s_src[i];
            dec_rd_en[i]          = s_en[i];
            rf_data[i*XLEN +: XLEN] = 32'hA000_0000 + i;
        end
        mem_valid = s_mv; mem_wr = s_mw; mem_dst = s_md; mem_result = 32'h1111_0000 + s_md;
        wb_valid  = s_wv; wb_wr  = s_ww; wb_dst  = s_wd; wb_result  = 32'h2222_0000 + s_wd;
        if (!s_rst) model_reset();
        hit = 0;
        for (int i = 0; i < NSRC; i++)
            if (s_en[i] && s_src[i] == m_d) hit = 1;
        e.tag   = tag;
        e.stall = s_rst && m_v && m_w && m_l && s_dv && hit;
        e.exv = m_v; e.exw = m_w; e.exl = m_l; e.exd = m_d;
        for (int i = 0; i < NSRC; i++) begin
            if (m_en[i] && s_mv && s_mw && s_md == m_src[i]) begin
                e.sel[i] = 2'b01; e.op[i] = 32'h1111_0000 + s_md;
            end else if (m_en[i] && s_wv && s_ww && s_wd == m_src[i]) begin
                e.sel[i] = 2'b10; e.op[i] = 32'h2222_0000 + s_wd;
            end else begin
                e.sel[i] = 2'b00; e.op[i] = 32'hA000_0000 + i;
            end
        end
        q.push_back(e);
        if (!s_rst) model_reset();
        else if (e.stall) begin
            m_v = 0; m_w = 0; m_l = 0;
            for (int i = 0; i < NSRC; i++) m_en[i] = 0;
        end else begin
            m_v = s_dv; m_w = s_dv && s_dw; m_l = s_dv && s_dl; m_d = s_dd;
            for (int i = 0; i < NSRC; i++) begin m_src[i] = s_src[i]; m_en[i] = s_dv && s_en[i]; end
        end
    endtask

    // monitor: compare outputs against the scoreboard away from the clock edge
    always @(negedge clk) begin
        #1;
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, "stall", {31'b0, stall}, {31'b0, e.stall});
            chk(e.tag, "ex_valid", {31'b0, ex_valid}, {31'b0, e.exv});
            chk(e.tag, "ex_wr", {31'b0, ex_wr}, {31'b0, e.exw});
            chk(e.tag, "ex_load", {31'b0, ex_load}, {31'b0, e.exl});
            chk(e.tag, "ex_dst", {27'b0, ex_dst}, {27'b0, e.exd});
            for (int i = 0; i < NSRC; i++) begin
                chk(e.tag, $sformatf("sel%0d", i), {30'b0, fwd_sel[i*2 +: 2]}, {30'b0, e.sel[i]});
                chk(e.tag, $sformatf("opnd%0d", i), ex_opnd[i*XLEN +: XLEN], e.op[i]);
            end
        end
    end

    task automatic dec(logic [RAW-1:0] a, logic [RAW-1:0] b, logic [RAW-1:0] c,
                       logic [2:0] en, logic [RAW-1:0] d, logic ld);
        s_dv = 1; s_dw = 1; s_dl = ld; s_dd = d;
        s_src[0] = a; s_src[1] = b; s_src[2] = c;
        for (int i = 0; i < NSRC; i++) s_en[i] = en[i];
    endtask

    initial begin
        model_reset();
        clr();
        s_rst = 0;
        step("R1 reset");
        step("R1 reset hold");
        s_rst = 1;
        step("R1 after reset");
        // A reads 1,2,3
        dec(1, 2, 3, 3'b111, 10, 0);
        step("R11 capture A");
        // A in execute: memory stage writes 1 -> slot0 bypass
        dec(4, 5, 6, 3'b111, 11, 0);
        s_mv = 1; s_mw = 1; s_md = 1;
        step("R2 R6 mem bypass slot0");
        // B in execute: wb writes 5, mem writes 6
        dec(7, 7, 0, 3'b111, 12, 0);
        s_md = 6; s_wv = 1; s_ww = 1; s_wd = 5;
        step("R3 R7 independent slots");
        // C (7,7,0) in execute: both stages write 7
        dec(0, 8, 9, 3'b101, 13, 0);
        s_md = 7; s_wd = 7;
        step("R4 mem beats wb");
        // D (0,8,9 en 101): mem writes 0 (register 0 forwarded), wb writes 8 but slot1 unused
        dec(2, 3, 4, 3'b111, 14, 0);
        s_md = 0; s_wd = 8;
        step("R5 R6 reg0 bypass, unused slot");
        // E (2,3,4): mem matches 2 without wr, wb matches 3 without valid
        dec(20, 21, 22, 3'b001, 9, 1);
        s_mv = 1; s_mw = 0; s_md = 2; s_wv = 0; s_ww = 1; s_wd = 3;
        step("R5 producer needs valid and wr");
        // load to 9 is in execute; decode reads 9 on slot2
        clr();
        dec(1, 2, 9, 3'b100, 15, 0);
        step("R8 load-use stall");
        // decode held, execute has bubble; load now in memory stage
        s_mv = 1; s_mw = 1; s_md = 9;
        step("R9 bubble no second stall");
        // reader enters execute, load at writeback
        clr();
        s_wv = 1; s_ww = 1; s_wd = 9;
        step("R3 load data bypass after stall");
        // load to 16, then unrelated, then reader two later
        clr();
        dec(0, 0, 0, 3'b000, 16, 1);
        step("R11 load capture");
        dec(17, 18, 19, 3'b111, 20, 0);
        step("R10 unrelated after load");
        dec(16, 0, 0, 3'b001, 21, 0);
        s_mv = 1; s_mw = 1; s_md = 16;
        step("R10 reader two slots after load");
        // non-load producer followed by user
        clr();
        dec(0, 0, 0, 3'b000, 22, 0);
        s_wv = 1; s_ww = 1; s_wd = 16;
        step("R10 alu producer");
        clr();
        dec(22, 22, 22, 3'b111, 23, 0);
        step("R10 no stall on alu producer");
        clr();
        s_mv = 1; s_mw = 1; s_md = 22;
        step("R2 R7 all slots from mem");
        // load-use on slot 1 with invalid decode: no stall
        clr();
        dec(0, 0, 0, 3'b000, 24, 1);
        step("R11 load 24");
        dec(0, 24, 0, 3'b010, 25, 0);
        s_dv = 0;
        step("R8 invalid reader no stall");
        clr();
        step("R1 idle");
        step("drain");
        @(negedge clk); #2;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule